// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block watches that application software keeps running. A down-counter runs on the system clock at all times, and no input can stop it. Software restarts the countdown by pulsing a kick strobe. If a full period passes with no kick, the block raises an interrupt and starts a second countdown at once. This gives software one period to recover. If that second period also passes with no kick, the block issues a fixed-length reset request pulse to the chip's reset logic.

The timeout period comes from a configuration input. The block samples that input only when it reloads the counter, so a change made in the middle of a count waits for the next reload. At power-on reset, and again after each reset pulse, the block starts from a built-in default period. The interrupt stays high until software clears it with an interrupt-acknowledge strobe or with a kick. Only a kick cancels the escalation.

Top module: `wdog_escalate`

## Requirements
- R1: The countdown cannot be stopped: holding irq_ack_i high all the time still gives an interrupt and then a reset request on the normal schedule.
- R2: A kick_i pulse sampled at a rising edge loads the counter with timeout_i (value T). With no further kicks, the expiry happens on the (T+1)th rising edge after the kick edge. A kick during a count restarts the full period.
- R3: The first expiry sets wdt_irq_o on the expiry edge, leaves rst_req_o low and reloads the counter from timeout_i.
- R4: A second expiry with no kick since the first one raises rst_req_o on that expiry edge.
- R5: A kick outside a reset pulse clears wdt_irq_o on the next edge and cancels the escalation, so the following expiry is again a first expiry with interrupt only.
- R6: irq_ack_i clears wdt_irq_o on the next edge but does not cancel the escalation. An expiry in the same cycle takes precedence over the acknowledge.
- R7: rst_req_o stays high for exactly RST_LEN cycles. Kicks during the pulse have no effect, and wdt_irq_o is low during the pulse.
- R8: After the active-low rst_ni is released, both outputs are low and the counter starts from DEF_TIMEOUT, so the first interrupt comes on the (DEF_TIMEOUT+1)th edge. The same holds from the edge that ends a reset pulse.
- R9: The block samples timeout_i only at a reload (a kick or a first expiry). A change to timeout_i in mid-count does not move the current expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Software service strobe, one cycle per kick |
| irq_ack_i | input | 1 | Clears the pending watchdog interrupt |
| timeout_i | input | CNT_W | Period value T, used at the next reload |
| wdt_irq_o | output | 1 | Watchdog interrupt after the first missed period |
| rst_req_o | output | 1 | System reset request pulse, RST_LEN cycles long |

## Verification
A wrong counter value or a wrong reload source shows at the ports as an interrupt that arrives on the wrong edge. The bench counts the exact number of edges from each kick, each expiry and each reset release, so an error of even one cycle shows within one period. A wrong escalation bit shows within two periods: either a reset request after a kick that should have cancelled it, or no reset request after an acknowledge that should not have cancelled it. A wrong pulse counter shows as a reset request of the wrong length, or as a default period that does not start from the edge that ends the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_PULSE = 1'b1
    } wdog_st_e;

    typedef struct packed {
        wdog_st_e st;
        logic     stage;   // first period already missed
        logic     irq;
    } wdog_ctl_t;

endpackage

// File: rtl/wdog_tmo_cnt.sv
module wdog_tmo_cnt #(
    parameter int unsigned W    = 16,
    parameter int unsigned INIT = 1000
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= W'(INIT);
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int unsigned LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic active_o,
    output logic last_o
);
    localparam int unsigned PW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic          active;
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (start_i && !p_q.active) begin
            p_d.active = 1'b1;
            p_d.left   = PW'(LEN - 1);
        end else if (p_q.active) begin
            if (p_q.left == '0) p_d.active = 1'b0;
            else                p_d.left   = p_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign active_o = p_q.active;
    assign last_o   = p_q.active && (p_q.left == '0);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DEF_TIMEOUT = 1000,
    parameter int unsigned RST_LEN     = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             kick_i,
    input  logic             irq_ack_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             wdt_irq_o,
    output logic             rst_req_o
);
    wdog_ctl_t        cur_q, cur_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             zero;
    logic             pulse_start;
    logic             pulse_active;
    logic             pulse_last;

    always_comb begin
        cur_d       = cur_q;
        load        = 1'b0;
        load_val    = timeout_i;
        pulse_start = 1'b0;
        unique case (cur_q.st)
            ST_RUN: begin
                if (kick_i) begin
                    load        = 1'b1;
                    cur_d.stage = 1'b0;
                    cur_d.irq   = 1'b0;
                end else if (zero) begin
                    if (!cur_q.stage) begin
                        load        = 1'b1;
                        cur_d.stage = 1'b1;
                        cur_d.irq   = 1'b1;
                    end else begin
                        pulse_start = 1'b1;
                        cur_d.st    = ST_PULSE;
                        cur_d.stage = 1'b0;
                        cur_d.irq   = 1'b0;
                    end
                end else if (irq_ack_i) begin
                    cur_d.irq = 1'b0;
                end
            end
            ST_PULSE: begin
                if (pulse_last) begin
                    cur_d.st = ST_RUN;
                    load     = 1'b1;
                    load_val = CNT_W'(DEF_TIMEOUT);
                end
            end
            default: cur_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= cur_d;
    end

    wdog_tmo_cnt #(
        .W    (CNT_W),
        .INIT (DEF_TIMEOUT)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (load_val),
        .zero_o     (zero)
    );

    wdog_rst_pulse #(
        .LEN (RST_LEN)
    ) u_pulse (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (pulse_start),
        .active_o (pulse_active),
        .last_o   (pulse_last)
    );

    assign wdt_irq_o = cur_q.irq;
    assign rst_req_o = pulse_active;
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk #(
    parameter int unsigned RST_LEN = 16
) (
    input logic clk_i,
    input logic rst_ni,
    input logic kick_i,
    input logic stage_i,
    input logic wdt_irq_o,
    input logic rst_req_o
);
    int unsigned run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        run_q <= 0;
        else if (rst_req_o) run_q <= run_q + 1;
        else                run_q <= 0;
    end

    a_r4_reset_after_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> $past(stage_i));

    a_r3_irq_without_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_irq_o) |-> !rst_req_o);

    a_r5_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_i && !rst_req_o) |=> (!wdt_irq_o && !rst_req_o));

    a_r7_irq_low_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> !wdt_irq_o);

    a_r7_pulse_not_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> (run_q < RST_LEN));

    a_r7_pulse_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_req_o) |-> ($past(run_q) == RST_LEN - 1));
endmodule

bind wdog_escalate wdog_escalate_chk #(
    .RST_LEN (RST_LEN)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (kick_i),
    .stage_i   (cur_q.stage),
    .wdt_irq_o (wdt_irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb_top;
    localparam int CNT_W   = 8;
    localparam int DEF_TMO = 20;
    localparam int RST_LEN = 16;

    typedef struct packed {
        logic [7:0] tmo;
        logic [8:0] exp_edges;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{tmo: 8'd3,  exp_edges: 9'd4},
        '{tmo: 8'd7,  exp_edges: 9'd8},
        '{tmo: 8'd0,  exp_edges: 9'd1},
        '{tmo: 8'd12, exp_edges: 9'd13},
        '{tmo: 8'd1,  exp_edges: 9'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             kick = 1'b0;
    logic             ack = 1'b0;
    logic [CNT_W-1:0] tmo = '0;
    logic             irq, rreq;
    int               total = 0;
    int               bad = 0;
    bit               done = 1'b0;

    always #5 clk = ~clk;

    wdog_escalate #(
        .CNT_W       (CNT_W),
        .DEF_TIMEOUT (DEF_TMO),
        .RST_LEN     (RST_LEN)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .kick_i    (kick),
        .irq_ack_i (ack),
        .timeout_i (tmo),
        .wdt_irq_o (irq),
        .rst_req_o (rreq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_irq(output int n);
        n = -1;
        for (int i = 1; i <= 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq) begin n = i; break; end
        end
    endtask

    task automatic wait_rst(output int n);
        n = -1;
        for (int i = 1; i <= 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rreq) begin n = i; break; end
        end
    endtask

    // counts edges until rst_req falls; kicks during the first kick_cycles
    task automatic pulse_len(input int kick_cycles, output int n);
        n = -1;
        for (int i = 1; i <= 300; i++) begin
            kick = (i <= kick_cycles);
            @(posedge clk);
            @(negedge clk);
            if (!rreq) begin n = i; break; end
        end
        kick = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        tmo = 8'd5;
        step(3);
        chk("R8 irq in reset", int'(irq), 0);
        chk("R8 rst_req in reset", int'(rreq), 0);
        rst_n = 1'b1;
        wait_irq(n);
        chk("R8 default period after rst_ni", n, DEF_TMO + 1);
        chk("R3 no reset on first expiry", int'(rreq), 0);
        do_kick();
        chk("R5 kick clears irq", int'(irq), 0);

        // vector table: period per timeout value
        foreach (VECS[k]) begin
            tmo = VECS[k].tmo;
            do_kick();
            wait_irq(n);
            chk("R2 table period", n, int'(VECS[k].exp_edges));
            chk("R3 table no reset", int'(rreq), 0);
            do_kick();
            chk("R5 table kick clears irq", int'(irq), 0);
        end

        // R2: kick in mid-count restarts full period
        tmo = 8'd10;
        do_kick();
        step(6);
        chk("R2 no irq before expiry", int'(irq), 0);
        do_kick();
        wait_irq(n);
        chk("R2 restart by kick", n, 11);
        do_kick();

        // R4 / R7 / R8: escalation, pulse, default after pulse
        tmo = 8'd6;
        do_kick();
        wait_irq(n);
        chk("R3 first expiry", n, 7);
        wait_rst(n);
        chk("R4 second expiry", n, 7);
        chk("R7 irq low in pulse", int'(irq), 0);
        pulse_len(4, n);
        chk("R7 pulse length with kicks ignored", n, RST_LEN);
        wait_irq(n);
        chk("R8 default period after pulse", n, DEF_TMO + 1);
        do_kick();

        // R5: kick between expiries prevents reset
        tmo = 8'd4;
        do_kick();
        wait_irq(n);
        chk("R5 first irq", n, 5);
        do_kick();
        wait_irq(n);
        chk("R5 again first expiry", n, 5);
        chk("R5 no reset after kick", int'(rreq), 0);
        do_kick();

        // R6: ack clears irq but escalation continues
        tmo = 8'd4;
        do_kick();
        wait_irq(n);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        chk("R6 ack clears irq", int'(irq), 0);
        wait_rst(n);
        chk("R6 reset despite ack", n, 4);
        pulse_len(0, n);
        chk("R7 pulse length", n, RST_LEN);
        do_kick();

        // R9: timeout change in mid-count waits for reload
        tmo = 8'd10;
        do_kick();
        step(3);
        tmo = 8'd3;
        wait_irq(n);
        chk("R9 old value kept in count", n, 8);
        wait_rst(n);
        chk("R9 new value at reload", n, 4);
        pulse_len(0, n);
        do_kick();

        // R1: ack held high cannot stop the countdown
        tmo = 8'd2;
        ack = 1'b1;
        do_kick();
        wait_irq(n);
        chk("R1 irq with ack held", n, 3);
        wait_rst(n);
        chk("R1 reset with ack held", n, 3);
        ack = 1'b0;
        pulse_len(0, n);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule